// File: doc/BRIEF.md
# Single-Bit Test Branch Resolver

This block resolves a family of conditional branches whose condition is one bit of a 64-bit source register, not a comparison between two registers. It sits in the execute stage of a 64-bit pipeline. Each cycle it takes the instruction word, the program counter of that instruction, the value read for the source register and a flag that marks the instruction as occupying a delay or forbidden slot. From these it produces a branch-valid flag, the taken decision, the target address, a reserved-instruction exception and a flag that says one delay-slot instruction follows.

The instruction word carries the position of the tested bit in two parts. Instruction bit 28 gives the top bit of the six-bit position and instruction bits 20:16 give the low five, so the forms with bit 28 set test register bits 32 to 63. Instruction bit 29 picks the polarity. The source register index comes straight from bits 25:21 and is driven without a register stage, so it can address the register file in the same cycle. The other outputs are computed combinationally and captured on the rising clock edge, which gives them a latency of one cycle.

Top module: `bbr_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every registered output (`br_valid_o`, `br_taken_o`, `br_target_o`, `ri_exc_o`, `dslot_o`) is zero after that edge.
- R2: An instruction is in the group when insn[31:30] = 2'b11 and insn[27:26] = 2'b10, which covers major opcodes 110010, 110110, 111010 and 111110. Any other word gives all-zero registered outputs.
- R3: Polarity is set by insn[29]. With 1, the branch is taken when the tested bit is 1. With 0, it is taken when the tested bit is 0.
- R4: The tested bit of `rs_val_i` sits at position {insn[28], insn[20:16]}, in the range 0 to 63, and no other register bit affects the decision.
- R5: `rs_sel_o` equals insn[25:21] in the same cycle, with no clock edge in between.
- R6: For a group instruction that is not in a slot, `br_target_o` = pc + 4 + (sign-extended insn[15:0] × 4), modulo 2^64. The target is reported whether or not the branch is taken.
- R7: A group instruction with `in_slot_i` high sets `ri_exc_o`. It clears `br_valid_o`, `br_taken_o`, `dslot_o` and `br_target_o`.
- R8: `dslot_o` is high exactly when `br_valid_o` is high, whether the branch is taken or not.
- R9: The registered outputs reflect the inputs sampled at the previous rising edge, so instructions on consecutive cycles each give their own result one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| rs_val_i | input | 64 | Value of the source register |
| in_slot_i | input | 1 | Instruction occupies a delay or forbidden slot |
| rs_sel_o | output | 5 | Source register index, combinational |
| br_valid_o | output | 1 | A bit-test branch was resolved |
| br_taken_o | output | 1 | Branch taken |
| br_target_o | output | 64 | Branch target address |
| ri_exc_o | output | 1 | Reserved-instruction exception |
| dslot_o | output | 1 | One delay-slot instruction follows |

## Verification
The assertions check on every cycle the invariants between the registered outputs: the taken and delay-slot flags imply valid, and an exception excludes a branch. They also check, one cycle after any input, that the group decode, the slot exception, the polarity applied to the selected bit and the target arithmetic match what the inputs call for. Only the bench's scenarios can show reset clearing, the combinational register index, wrap of the target past 2^64, the high-half bit positions, and the pairing of back-to-back instructions with their own results.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  // Fields of the instruction word whose positions drive decode behaviour
  localparam int unsigned GRP_HI_MSB = 31;
  localparam int unsigned GRP_LO_MSB = 27;
  localparam int unsigned POL_BIT    = 29;
  localparam int unsigned POS_HI_BIT = 28;
  localparam int unsigned SRC_LSB    = 21;
  localparam int unsigned POS_LO_LSB = 16;

  localparam logic [1:0] GRP_HI_VAL = 2'b11;
  localparam logic [1:0] GRP_LO_VAL = 2'b10;

  typedef struct packed {
    logic valid;
    logic taken;
    logic exc;
    logic dslot;
  } bbr_flags_t;
endpackage

// File: rtl/bbr_decode.sv
module bbr_decode
  import bbr_pkg::*;
#(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned POS_W  = 6
) (
  input  logic [INSN_W-1:0] insn,
  output logic              hit,
  output logic              pol,
  output logic [POS_W-1:0]  pos,
  output logic [IDX_W-1:0]  src_idx,
  output logic [OFF_W-1:0]  off
);
  localparam int unsigned LO_W = POS_W - 1;

  logic [1:0] grp_hi;
  logic [1:0] grp_lo;

  always_comb begin
    grp_hi  = insn[GRP_HI_MSB -: 2];
    grp_lo  = insn[GRP_LO_MSB -: 2];
    hit     = (grp_hi == GRP_HI_VAL) && (grp_lo == GRP_LO_VAL);
    pol     = insn[POL_BIT];
    pos     = {insn[POS_HI_BIT], insn[POS_LO_LSB +: LO_W]};
    src_idx = insn[SRC_LSB +: IDX_W];
    off     = insn[OFF_W-1:0];
  end
endmodule

// File: rtl/bbr_bitsel.sv
module bbr_bitsel #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned POS_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]  val,
  input  logic [POS_W-1:0] pos,
  output logic             bit_out
);
  // One-hot select, then OR-reduce: a flat AND-OR mux
  logic [XLEN-1:0] hot;

  for (genvar g = 0; g < XLEN; g++) begin : g_sel
    assign hot[g] = val[g] & (pos == POS_W'(g));
  end

  assign bit_out = |hot;
endmodule

// File: rtl/bbr_target.sv
module bbr_target #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned OFF_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  output logic [XLEN-1:0]  tgt
);
  localparam int unsigned EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] disp;

  always_comb begin
    disp = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
    tgt  = pc + XLEN'(4) + disp;
  end
endmodule

// File: rtl/bbr_unit.sv
module bbr_unit
  import bbr_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned INSN_W = 32,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic              in_slot_i,
  output logic [IDX_W-1:0]  rs_sel_o,
  output logic              br_valid_o,
  output logic              br_taken_o,
  output logic [XLEN-1:0]   br_target_o,
  output logic              ri_exc_o,
  output logic              dslot_o
);
  localparam int unsigned POS_W = $clog2(XLEN);

  logic             hit;
  logic             pol;
  logic [POS_W-1:0] pos;
  logic [OFF_W-1:0] off;
  logic             tbit;
  logic [XLEN-1:0]  tgt;

  bbr_flags_t       nxt_flags;
  bbr_flags_t       q_flags;
  logic [XLEN-1:0]  nxt_tgt;
  logic [XLEN-1:0]  q_tgt;

  bbr_decode #(
    .INSN_W(INSN_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .POS_W(POS_W)
  ) u_dec (
    .insn(insn_i), .hit(hit), .pol(pol), .pos(pos),
    .src_idx(rs_sel_o), .off(off)
  );

  bbr_bitsel #(.XLEN(XLEN), .POS_W(POS_W)) u_sel (
    .val(rs_val_i), .pos(pos), .bit_out(tbit)
  );

  bbr_target #(.XLEN(XLEN), .OFF_W(OFF_W)) u_tgt (
    .pc(pc_i), .off(off), .tgt(tgt)
  );

  always_comb begin
    logic resolve;
    resolve         = hit & ~in_slot_i;
    nxt_flags.valid = resolve;
    nxt_flags.taken = resolve & (tbit == pol);
    nxt_flags.exc   = hit & in_slot_i;
    nxt_flags.dslot = resolve;
    nxt_tgt         = resolve ? tgt : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_flags <= '0;
      q_tgt   <= '0;
    end else begin
      q_flags <= nxt_flags;
      q_tgt   <= nxt_tgt;
    end
  end

  assign br_valid_o  = q_flags.valid;
  assign br_taken_o  = q_flags.taken;
  assign ri_exc_o    = q_flags.exc;
  assign dslot_o     = q_flags.dslot;
  assign br_target_o = q_tgt;
endmodule

// File: rtl/bbr_unit_chk.sv
module bbr_unit_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned INSN_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [INSN_W-1:0] insn_i,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   rs_val_i,
  input logic              in_slot_i,
  input logic              br_valid_o,
  input logic              br_taken_o,
  input logic [XLEN-1:0]   br_target_o,
  input logic              ri_exc_o,
  input logic              dslot_o
);
  logic            grp;
  logic [5:0]      bpos;
  logic            tbit;
  logic [XLEN-1:0] want_tgt;

  assign grp      = (insn_i[31:30] == 2'b11) && (insn_i[27:26] == 2'b10);
  assign bpos     = {insn_i[28], insn_i[20:16]};
  assign tbit     = rs_val_i[bpos];
  assign want_tgt = pc_i + XLEN'(4) + {{(XLEN-18){insn_i[15]}}, insn_i[15:0], 2'b00};

  assert_taken_needs_valid_R3: assert property (@(posedge clk) disable iff (rst)
    br_taken_o |-> br_valid_o);

  assert_dslot_matches_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (br_valid_o |-> dslot_o) and (dslot_o |-> br_valid_o));

  assert_exc_blocks_branch_R7: assert property (@(posedge clk) disable iff (rst)
    ri_exc_o |-> (!br_valid_o && !br_taken_o && !dslot_o && br_target_o == '0));

  assert_slot_raises_exc_R7: assert property (@(posedge clk) disable iff (rst)
    (grp && in_slot_i) |=> ri_exc_o);

  assert_foreign_word_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !grp |=> (!br_valid_o && !ri_exc_o && !br_taken_o && br_target_o == '0));

  assert_polarity_bit_R4: assert property (@(posedge clk) disable iff (rst)
    (grp && !in_slot_i) |=> (br_valid_o && (br_taken_o == ($past(insn_i[29]) == $past(tbit)))));

  assert_target_sum_R6: assert property (@(posedge clk) disable iff (rst)
    (grp && !in_slot_i) |=> (br_target_o == $past(want_tgt)));
endmodule

bind bbr_unit bbr_unit_chk #(.XLEN(XLEN), .INSN_W(INSN_W)) u_bbr_chk (
  .clk(clk), .rst(rst), .insn_i(insn_i), .pc_i(pc_i), .rs_val_i(rs_val_i),
  .in_slot_i(in_slot_i), .br_valid_o(br_valid_o), .br_taken_o(br_taken_o),
  .br_target_o(br_target_o), .ri_exc_o(ri_exc_o), .dslot_o(dslot_o)
);

// File: tb/test_bbr_unit.sv
`timescale 1ns/1ps
module test_bbr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn_i = '0;
  logic [63:0] pc_i = '0;
  logic [63:0] rs_val_i = '0;
  logic        in_slot_i = 1'b0;
  logic [4:0]  rs_sel_o;
  logic        br_valid_o, br_taken_o, ri_exc_o, dslot_o;
  logic [63:0] br_target_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bbr_unit i_bbr_unit (
    .clk(clk), .rst(rst), .insn_i(insn_i), .pc_i(pc_i), .rs_val_i(rs_val_i),
    .in_slot_i(in_slot_i), .rs_sel_o(rs_sel_o), .br_valid_o(br_valid_o),
    .br_taken_o(br_taken_o), .br_target_o(br_target_o), .ri_exc_o(ri_exc_o),
    .dslot_o(dslot_o)
  );

  function automatic logic [31:0] mk(input logic pol, input logic hi, input logic [4:0] rs,
                                     input logic [4:0] lo, input logic [15:0] off);
    return {2'b11, pol, hi, 2'b10, rs, lo, off};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected outputs from the requirements (R2, R3, R4, R6, R7, R8)
  task automatic expect_of(input logic [31:0] w, input logic [63:0] pc, input logic [63:0] rv,
                           input logic slot, output logic v, output logic t,
                           output logic [63:0] tg, output logic e);
    logic g;
    logic [5:0] p;
    g  = (w[31:30] == 2'b11) && (w[27:26] == 2'b10);
    p  = {w[28], w[20:16]};
    v  = g && !slot;
    e  = g && slot;
    t  = v && (rv[p] == w[29]);
    tg = v ? pc + 64'd4 + {{46{w[15]}}, w[15:0], 2'b00} : 64'd0;
  endtask

  // Drive at a falling edge, check after the next falling edge
  task automatic run_one(input string req, input logic [31:0] w, input logic [63:0] pc,
                         input logic [63:0] rv, input logic slot);
    logic v, t, e;
    logic [63:0] tg;
    insn_i = w; pc_i = pc; rs_val_i = rv; in_slot_i = slot;
    expect_of(w, pc, rv, slot, v, t, tg, e);
    @(posedge clk); @(negedge clk);
    chk({req, " valid"}, 64'(br_valid_o), 64'(v));
    chk({req, " taken"}, 64'(br_taken_o), 64'(t));
    chk({req, " target"}, br_target_o, tg);
    chk({req, " exc"}, 64'(ri_exc_o), 64'(e));
    chk({req, " dslot R8"}, 64'(dslot_o), 64'(v));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    insn_i = mk(1'b1, 1'b0, 5'd3, 5'd0, 16'h0010); rs_val_i = 64'h1; pc_i = 64'h1000;
    @(posedge clk); @(negedge clk);
    chk("R1 valid", 64'(br_valid_o), 64'd0);
    chk("R1 taken", 64'(br_taken_o), 64'd0);
    chk("R1 target", br_target_o, 64'd0);
    chk("R1 exc", 64'(ri_exc_o), 64'd0);
    chk("R1 dslot", 64'(dslot_o), 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_opcodes();
    for (int k = 0; k < 4; k++) begin
      logic pol, hi;
      pol = k[1]; hi = k[0];
      run_one("R2 opcode", mk(pol, hi, 5'd7, 5'd4, 16'h0020), 64'h8000, 64'h0000_0010_0000_0010, 1'b0);
    end
  endtask

  task automatic t_polarity();
    run_one("R3 set/one",   mk(1'b1, 1'b0, 5'd1, 5'd9, 16'h4), 64'h200, 64'h200, 1'b0);
    run_one("R3 set/zero",  mk(1'b1, 1'b0, 5'd1, 5'd9, 16'h4), 64'h200, ~64'h200, 1'b0);
    run_one("R3 clr/zero",  mk(1'b0, 1'b0, 5'd1, 5'd9, 16'h4), 64'h200, ~64'h200, 1'b0);
    run_one("R3 clr/one",   mk(1'b0, 1'b0, 5'd1, 5'd9, 16'h4), 64'h200, 64'h200, 1'b0);
  endtask

  task automatic t_positions();
    for (int b = 0; b < 64; b += 7) begin
      run_one("R4 walk one", mk(1'b1, b[5], 5'd2, b[4:0], 16'h1), 64'h40, 64'd1 << b, 1'b0);
      run_one("R4 walk zero", mk(1'b1, b[5], 5'd2, b[4:0], 16'h1), 64'h40, ~(64'd1 << b), 1'b0);
    end
    run_one("R4 bit63", mk(1'b1, 1'b1, 5'd2, 5'd31, 16'h1), 64'h40, 64'h8000_0000_0000_0000, 1'b0);
    run_one("R4 bit32", mk(1'b0, 1'b1, 5'd2, 5'd0, 16'h1), 64'h40, 64'h0000_0000_FFFF_FFFF, 1'b0);
    run_one("R4 bit31", mk(1'b1, 1'b0, 5'd2, 5'd31, 16'h1), 64'h40, 64'h0000_0001_0000_0000, 1'b0);
  endtask

  task automatic t_src_index();
    for (int r = 0; r < 32; r += 5) begin
      insn_i = mk(1'b0, 1'b0, r[4:0], 5'd0, 16'h0);
      #1;
      chk("R5 rs_sel", 64'(rs_sel_o), 64'(r));
    end
    insn_i = 32'h03E0_0000;
    #1;
    chk("R5 rs_sel foreign word", 64'(rs_sel_o), 64'd31);
    @(negedge clk);
  endtask

  task automatic t_target();
    run_one("R6 negative", mk(1'b1, 1'b0, 5'd0, 5'd0, 16'hFFFF), 64'h0000_0000_0000_1000, 64'h0, 1'b0);
    run_one("R6 max fwd",  mk(1'b1, 1'b0, 5'd0, 5'd0, 16'h7FFF), 64'h0000_0000_0010_0000, 64'h1, 1'b0);
    run_one("R6 min back", mk(1'b0, 1'b0, 5'd0, 5'd0, 16'h8000), 64'h0000_0000_0010_0000, 64'h0, 1'b0);
    run_one("R6 wrap",     mk(1'b1, 1'b0, 5'd0, 5'd0, 16'h0001), 64'hFFFF_FFFF_FFFF_FFFC, 64'h1, 1'b0);
  endtask

  task automatic t_slot();
    run_one("R7 slot taken-like", mk(1'b1, 1'b0, 5'd4, 5'd0, 16'h10), 64'h500, 64'h1, 1'b1);
    run_one("R7 slot high form",  mk(1'b0, 1'b1, 5'd4, 5'd3, 16'h10), 64'h500, 64'h0, 1'b1);
    run_one("R7 foreign in slot", 32'h1000_0004, 64'h500, 64'h1, 1'b1);
  endtask

  task automatic t_foreign();
    run_one("R2 op 000011",  32'h0C00_0010, 64'h600, 64'hFFFF, 1'b0);
    run_one("R2 op 110011",  32'hCC00_0010, 64'h600, 64'hFFFF, 1'b0);
    run_one("R2 op 100010",  32'h8800_0010, 64'h600, 64'hFFFF, 1'b0);
    run_one("R2 op 011110",  32'h7800_0010, 64'h600, 64'hFFFF, 1'b0);
    run_one("R2 op 110001",  32'hC400_0010, 64'h600, 64'hFFFF, 1'b0);
  endtask

  task automatic t_back_to_back();
    insn_i = mk(1'b1, 1'b0, 5'd1, 5'd0, 16'h0008); pc_i = 64'h100; rs_val_i = 64'h1; in_slot_i = 1'b0;
    @(posedge clk); #1;
    insn_i = mk(1'b1, 1'b1, 5'd1, 5'd0, 16'hFFFE); pc_i = 64'h900; rs_val_i = 64'h1;
    chk("R9 first taken", 64'(br_taken_o), 64'd1);
    chk("R9 first target", br_target_o, 64'h124);
    @(posedge clk); #1;
    insn_i = 32'h0;
    chk("R9 second taken", 64'(br_taken_o), 64'd0);
    chk("R9 second target", br_target_o, 64'h8FC);
    @(posedge clk); #1;
    chk("R9 third valid", 64'(br_valid_o), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_opcodes();
    t_polarity();
    t_positions();
    t_src_index();
    t_target();
    t_slot();
    t_foreign();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule